// File: doc/BRIEF.md
# Descrambler and Code-Group Aligner

This block sits behind the clock-recovery stage of a 100BASE-TX style receiver. Each core clock it accepts 0, 1 or 2 recovered line bits together with a count. It removes the line scrambling with an 11-stage keystream generator and finds the 5-bit code-group boundary from the start-of-stream delimiter. It then turns each aligned code group into a 4-bit nibble with a kind tag.

The keystream generator synchronises itself while the line is idle. During that time the plaintext is known to be all ones, so the inverted received bits are the keystream. Once it is locked, descrambled bits go into a 10-bit window. While no alignment is held, the window is searched for the start delimiter. While alignment is held, every fifth bit closes a code group, which is decoded and reported.

The output is sparse. It is a registered nibble with a valid strobe at the core clock, at most one per cycle. Downstream logic therefore does not care how bits arrived.

Top module: `ds_rx_align`

## Requirements
- R1: `bitCount` is 0, 1 or 2. `bitsIn[0]` is the earlier line bit and `bitsIn[1]` the later one. A count of 0 advances no state.
- R2: After reset, the first 11 received bits are taken as idle. Their inverted values load the keystream state, and no nibble is reported until this lock is complete.
- R3: Once locked, the keystream follows k[n] = k[n-11] XOR k[n-9], and each plaintext bit is the received bit XOR k[n].
- R4: While unaligned, the plaintext sequence 11000 followed by 10001 (leftmost bit first on the line) produces one output with kind 1 (start) and nibble 0. The next code group begins with the following bit.
- R5: While aligned, each data code group produces kind 0 with its nibble: 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R6: While aligned, group 01101 produces kind 2 (end) with nibble 0 and drops alignment. The groups that follow it are not reported.
- R7: While aligned, group 11111 produces kind 3 (idle). The fourth consecutive idle group drops alignment, and later groups are not reported until the next start delimiter.
- R8: While aligned, any other group produces kind 0 with the error flag set and nibble 0.
- R9: A result is presented, with `nibValid` high for one cycle, right after the clock edge that samples the bit completing its group. There is at most one result per cycle.
- R10: While unaligned, nothing except a start result is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitsIn | input | 2 | Recovered bits, bit 0 earlier |
| bitCount | input | 2 | Number of valid bits in `bitsIn` (0 to 2) |
| nibble | output | 4 | Decoded nibble |
| nibValid | output | 1 | Result strobe |
| nibKind | output | 2 | 0 data, 1 start, 2 end, 3 idle |
| nibErr | output | 1 | Invalid code group seen |

## Verification
The assertions rely on two things about the input. The count never exceeds two. The line carries idle for at least the first eleven bits after reset, because otherwise the keystream state loads with garbage and no output property is meaningful. The stimulus meets both conditions. It opens with thirty idle groups, keeps the keystream running continuously across frames, and draws every per-cycle count from 0 to 2, including long stretches of zero counts. Each frame is framed by idle, and the directed cases choose data nibbles that cannot form a false start delimiter once alignment has been dropped.

// File: rtl/ds_pkg.sv
package ds_pkg;
  localparam int GRP_BITS = 5;

  localparam logic [4:0] CODE_J = 5'b11000;
  localparam logic [4:0] CODE_K = 5'b10001;
  localparam logic [4:0] CODE_T = 5'b01101;
  localparam logic [4:0] CODE_I = 5'b11111;

  typedef enum logic [1:0] {
    KIND_DATA  = 2'd0,
    KIND_START = 2'd1,
    KIND_END   = 2'd2,
    KIND_IDLE  = 2'd3
  } symKind_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadKey;
    logic aligned;
  } dpCtrl_t;

  // datapath -> control events
  typedef struct packed {
    logic       jkSeen;
    logic       grpDone;
    logic [4:0] code;
  } dpEvt_t;

  // returns {ok, nibble}
  function automatic logic [4:0] dec5b(input logic [4:0] c);
    case (c)
      5'b11110: return {1'b1, 4'h0};
      5'b01001: return {1'b1, 4'h1};
      5'b10100: return {1'b1, 4'h2};
      5'b10101: return {1'b1, 4'h3};
      5'b01010: return {1'b1, 4'h4};
      5'b01011: return {1'b1, 4'h5};
      5'b01110: return {1'b1, 4'h6};
      5'b01111: return {1'b1, 4'h7};
      5'b10010: return {1'b1, 4'h8};
      5'b10011: return {1'b1, 4'h9};
      5'b10110: return {1'b1, 4'hA};
      5'b10111: return {1'b1, 4'hB};
      5'b11010: return {1'b1, 4'hC};
      5'b11011: return {1'b1, 4'hD};
      5'b11100: return {1'b1, 4'hE};
      5'b11101: return {1'b1, 4'hF};
      default:  return 5'b0;
    endcase
  endfunction
endpackage

// File: rtl/ds_datapath.sv
module ds_datapath
  import ds_pkg::*;
#(
  parameter int LFSR_LEN = 11,
  parameter int LFSR_TAP = 9,
  parameter int MAX_BITS = 2,
  parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [MAX_BITS-1:0] bitsIn,
  input  logic [CNT_W-1:0]    bitCount,
  input  dpCtrl_t             ctrl,
  output dpEvt_t              evt
);
  localparam int WIN = 2 * GRP_BITS;
  localparam int PW  = $clog2(GRP_BITS);

  logic [LFSR_LEN-1:0] lfsrQ, lfsrN;
  logic [WIN-1:0]      winQ, winN;
  logic [PW-1:0]       phaseQ, phaseN;

  // process up to MAX_BITS line bits in order within one cycle
  always_comb begin
    logic key;
    logic plain;
    logic al;
    lfsrN  = lfsrQ;
    winN   = winQ;
    phaseN = phaseQ;
    al     = ctrl.aligned;
    evt    = '0;
    key    = 1'b0;
    plain  = 1'b0;
    for (int i = 0; i < MAX_BITS; i++) begin
      if (i < int'(bitCount)) begin
        key = lfsrN[LFSR_LEN-1] ^ lfsrN[LFSR_TAP-1];
        if (ctrl.loadKey) begin
          lfsrN = {lfsrN[LFSR_LEN-2:0], ~bitsIn[i]};
        end else begin
          plain = bitsIn[i] ^ key;
          lfsrN = {lfsrN[LFSR_LEN-2:0], key};
          winN  = {winN[WIN-2:0], plain};
          if (!al) begin
            if (winN == {CODE_J, CODE_K}) begin
              al         = 1'b1;
              phaseN     = '0;
              evt.jkSeen = 1'b1;
            end
          end else if (phaseN == PW'(GRP_BITS - 1)) begin
            phaseN      = '0;
            evt.grpDone = 1'b1;
            evt.code    = winN[GRP_BITS-1:0];
            if (winN[GRP_BITS-1:0] == CODE_T) al = 1'b0;
          end else begin
            phaseN = phaseN + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ  <= '0;
      winQ   <= '1;
      phaseQ <= '0;
    end else begin
      lfsrQ  <= lfsrN;
      winQ   <= winN;
      phaseQ <= phaseN;
    end
  end

  assert_count_legal_R1: assert property (@(posedge clk) disable iff (!rstN)
    int'(bitCount) <= MAX_BITS);

  assert_jk_unaligned_R4: assert property (@(posedge clk) disable iff (!rstN)
    evt.jkSeen |-> !ctrl.aligned);
endmodule

// File: rtl/ds_control.sv
module ds_control
  import ds_pkg::*;
#(
  parameter int LOCK_BITS  = 11,
  parameter int IDLE_LIMIT = 4,
  parameter int CNT_W      = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] bitCount,
  input  dpEvt_t           evt,
  output dpCtrl_t          ctrl,
  output logic [3:0]       nibble,
  output logic             nibValid,
  output logic [1:0]       nibKind,
  output logic             nibErr
);
  localparam int LCW = $clog2(LOCK_BITS + 4);
  localparam int ICW = $clog2(IDLE_LIMIT + 1);

  logic           locked;
  logic           aligned;
  logic [LCW-1:0] lockCnt, lockSum;
  logic [ICW-1:0] idleRun;
  logic [4:0]     decoded;
  symKind_t       kindN;
  logic [3:0]     nibN;
  logic           errN;

  assign ctrl.loadKey = !locked;
  assign ctrl.aligned = aligned;
  assign lockSum      = lockCnt + LCW'(bitCount);
  assign decoded      = dec5b(evt.code);

  always_comb begin
    kindN = KIND_DATA;
    nibN  = 4'h0;
    errN  = 1'b0;
    if (evt.jkSeen) begin
      kindN = KIND_START;
    end else if (evt.code == CODE_I) begin
      kindN = KIND_IDLE;
    end else if (evt.code == CODE_T) begin
      kindN = KIND_END;
    end else if (decoded[4]) begin
      nibN = decoded[3:0];
    end else begin
      errN = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked   <= 1'b0;
      lockCnt  <= '0;
      aligned  <= 1'b0;
      idleRun  <= '0;
      nibValid <= 1'b0;
      nibKind  <= KIND_DATA;
      nibble   <= 4'h0;
      nibErr   <= 1'b0;
    end else begin
      if (!locked) begin
        lockCnt <= lockSum;
        if (int'(lockSum) >= LOCK_BITS) locked <= 1'b1;
      end
      if (evt.jkSeen) begin
        aligned <= 1'b1;
        idleRun <= '0;
      end else if (evt.grpDone) begin
        if (evt.code == CODE_T) begin
          aligned <= 1'b0;
          idleRun <= '0;
        end else if (evt.code == CODE_I) begin
          if (int'(idleRun) == IDLE_LIMIT - 1) begin
            aligned <= 1'b0;
            idleRun <= '0;
          end else begin
            idleRun <= idleRun + 1'b1;
          end
        end else begin
          idleRun <= '0;
        end
      end
      nibValid <= evt.jkSeen | evt.grpDone;
      nibKind  <= kindN;
      nibble   <= nibN;
      nibErr   <= errN;
    end
  end

  assert_out_needs_lock_R2: assert property (@(posedge clk) disable iff (!rstN)
    nibValid |-> $past(locked));

  assert_start_from_search_R4: assert property (@(posedge clk) disable iff (!rstN)
    (nibValid && nibKind == KIND_START) |-> !$past(aligned));

  assert_end_drops_R6: assert property (@(posedge clk) disable iff (!rstN)
    (nibValid && nibKind == KIND_END) |-> !aligned);

  assert_idle_bounded_R7: assert property (@(posedge clk) disable iff (!rstN)
    int'(idleRun) < IDLE_LIMIT);
endmodule

// File: rtl/ds_rx_align.sv
module ds_rx_align
  import ds_pkg::*;
#(
  parameter int LFSR_LEN   = 11,
  parameter int LFSR_TAP   = 9,
  parameter int LOCK_BITS  = 11,
  parameter int IDLE_LIMIT = 4,
  parameter int MAX_BITS   = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [MAX_BITS-1:0]              bitsIn,
  input  logic [$clog2(MAX_BITS+1)-1:0]    bitCount,
  output logic [3:0]                       nibble,
  output logic                             nibValid,
  output logic [1:0]                       nibKind,
  output logic                             nibErr
);
  localparam int CNT_W = $clog2(MAX_BITS + 1);

  dpCtrl_t ctrl;
  dpEvt_t  evt;

  ds_datapath #(
    .LFSR_LEN(LFSR_LEN), .LFSR_TAP(LFSR_TAP), .MAX_BITS(MAX_BITS), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .bitsIn(bitsIn), .bitCount(bitCount),
    .ctrl(ctrl), .evt(evt)
  );

  ds_control #(
    .LOCK_BITS(LOCK_BITS), .IDLE_LIMIT(IDLE_LIMIT), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .bitCount(bitCount), .evt(evt), .ctrl(ctrl),
    .nibble(nibble), .nibValid(nibValid), .nibKind(nibKind), .nibErr(nibErr)
  );
endmodule

// File: tb/ds_rx_align_tb.sv
`timescale 1ns/1ps
module ds_rx_align_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] bitsIn = '0;
  logic [1:0] bitCount = '0;
  logic [3:0] nibble;
  logic       nibValid;
  logic [1:0] nibKind;
  logic       nibErr;

  always #2.5 clk = ~clk;

  ds_rx_align u_dut (
    .clk(clk), .rstN(rstN), .bitsIn(bitsIn), .bitCount(bitCount),
    .nibble(nibble), .nibValid(nibValid), .nibKind(nibKind), .nibErr(nibErr)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rateMode = 1;
  int popTotal = 0;
  int pushTotal = 0;
  int markIdx = -1;
  int markCyc = 0;
  int endCyc = 0;
  logic        bitQ[$];
  logic [6:0]  gotQ[$];
  logic [6:0]  expQ[$];
  logic [10:0] kh = 11'h2B5;

  // {len, rateMode, payload}; nibble i = payload[4i+:4]
  localparam logic [79:0] VEC [6] = '{
    {8'd8,  8'd0, 64'h0000_0000_DEAD_BEEF},
    {8'd16, 8'd1, 64'h0123_4567_89AB_CDEF},
    {8'd1,  8'd2, 64'h0000_0000_0000_000F},
    {8'd12, 8'd3, 64'h0000_5A5A_C3C3_3C3C},
    {8'd16, 8'd0, 64'hFEDC_BA98_7654_3210},
    {8'd5,  8'd1, 64'h0000_0000_000A_0000}
  };

  function automatic logic [4:0] enc(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  function automatic logic [6:0] ev(input logic [1:0] k, input logic e, input logic [3:0] n);
    return {k, e, n};
  endfunction

  // sample outputs, then drive next bits, all at the falling edge
  always @(negedge clk) begin
    int n;
    cyc++;
    if (rstN && nibValid) begin
      gotQ.push_back({nibKind, nibErr, nibble});
      if (nibKind == 2'd2) endCyc = cyc;
    end
    case (rateMode)
      0: n = $urandom_range(0, 2);
      1: n = 2;
      2: n = 1;
      default: n = ($urandom_range(0, 3) == 0) ? 1 + $urandom_range(0, 1) : 0;
    endcase
    if (!rstN) n = 0;
    if (n > bitQ.size()) n = bitQ.size();
    bitsIn = '0;
    for (int i = 0; i < n; i++) begin
      bitsIn[i] = bitQ.pop_front();
      if (popTotal == markIdx) markCyc = cyc;
      popTotal++;
    end
    bitCount = 2'(n);
  end

  task automatic pushPlain(input logic b);
    logic k;
    k = kh[10] ^ kh[8];
    kh = {kh[9:0], k};
    bitQ.push_back(b ^ k);
    pushTotal++;
  endtask

  task automatic pushGroup(input logic [4:0] c);
    for (int i = 4; i >= 0; i--) pushPlain(c[i]);
  endtask

  task automatic pushIdle(input int n);
    for (int i = 0; i < n; i++) pushGroup(5'b11111);
  endtask

  task automatic drain();
    while (bitQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compareEvents(input string req);
    check(gotQ.size() == expQ.size(), req, gotQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      check(gotQ[i] == expQ[i], req, gotQ[i], expQ[i]);
    gotQ.delete();
    expQ.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(nibValid == 1'b0, "R2 reset", nibValid, 0);
    rstN = 1'b1;
    // lock on idle; nothing reported while unaligned (R2, R10)
    pushIdle(30);
    drain();
    compareEvents("R2 R10 idle only");

    // frame vectors: R1 R3 R4 R5 R6 R9
    for (int v = 0; v < 6; v++) begin
      int len;
      len = int'(VEC[v][79:72]);
      rateMode = int'(VEC[v][71:64]);
      pushIdle(4);
      pushGroup(5'b11000);
      pushGroup(5'b10001);
      expQ.push_back(ev(2'd1, 1'b0, 4'h0));
      for (int i = 0; i < len; i++) begin
        pushGroup(enc(VEC[v][4*i +: 4]));
        expQ.push_back(ev(2'd0, 1'b0, VEC[v][4*i +: 4]));
      end
      markIdx = pushTotal + 4;
      pushGroup(5'b01101);
      expQ.push_back(ev(2'd2, 1'b0, 4'h0));
      pushGroup(5'b00111);
      pushIdle(6);
      drain();
      compareEvents("R5 R6 frame");
      check(endCyc == markCyc + 1, "R9 latency", endCyc - markCyc, 1);
    end

    // invalid code inside a frame (R8)
    rateMode = 0;
    pushIdle(3);
    pushGroup(5'b11000);
    pushGroup(5'b10001);
    pushGroup(enc(4'h3));
    pushGroup(5'b00000);
    pushGroup(enc(4'h9));
    pushGroup(5'b01101);
    pushGroup(5'b00111);
    pushIdle(5);
    expQ.push_back(ev(2'd1, 1'b0, 4'h0));
    expQ.push_back(ev(2'd0, 1'b0, 4'h3));
    expQ.push_back(ev(2'd0, 1'b1, 4'h0));
    expQ.push_back(ev(2'd0, 1'b0, 4'h9));
    expQ.push_back(ev(2'd2, 1'b0, 4'h0));
    drain();
    compareEvents("R8 invalid code");

    // idle run drops alignment; later data ignored (R7, R10)
    rateMode = 3;
    pushIdle(3);
    pushGroup(5'b11000);
    pushGroup(5'b10001);
    pushGroup(enc(4'h1));
    pushIdle(4);
    for (int i = 0; i < 3; i++) pushGroup(enc(4'h5));
    pushGroup(5'b01101);
    pushGroup(5'b00111);
    pushIdle(5);
    expQ.push_back(ev(2'd1, 1'b0, 4'h0));
    expQ.push_back(ev(2'd0, 1'b0, 4'h1));
    for (int i = 0; i < 4; i++) expQ.push_back(ev(2'd3, 1'b0, 4'h0));
    drain();
    compareEvents("R7 R10 idle drop");

    // new start delimiter realigns (R4)
    rateMode = 1;
    pushGroup(5'b11000);
    pushGroup(5'b10001);
    pushGroup(enc(4'hC));
    pushGroup(5'b01101);
    pushGroup(5'b00111);
    pushIdle(4);
    expQ.push_back(ev(2'd1, 1'b0, 4'h0));
    expQ.push_back(ev(2'd0, 1'b0, 4'hC));
    expQ.push_back(ev(2'd2, 1'b0, 4'h0));
    drain();
    compareEvents("R4 realign");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule